// File: doc/BRIEF.md
# PC Sample Profiling Register Unit

This unit sits on the debug side of a processor and supports coarse, sample-based profiling. Each time the processor reports that a branch has retired, the unit records the current instruction address together with the security state (non-secure flag) and privilege level. A debugger reads the record through a 32-bit read port.

Reading the low word is the main operation. It returns the lower half of the recorded address. As a side effect, it copies the upper half and the context bits into shadow registers, and the debugger then reads those through the high word. If no new branch has been recorded since the last consuming read, the low word returns the previous value and raises a stale flag. While the processor is halted for debug, or while profiling is prohibited, the low word returns a fixed all-ones sentinel.

Power and lock conditions turn every access into an error response. A software lock on the memory-mapped path suppresses the side effect of a low-word read. A format-select input chooses how the high word is laid out.

Top module: `pcsamp_unit`

## Requirements
- R1: The low word is at offset 0x0A0 and the high word at offset 0x0AC. A read of any other offset returns zero with no error. Every read gives a one-cycle response: `rsp_valid`, `rsp_err`, `rsp_data` and `rsp_stale` are registered on the clock edge that samples `rd_en`, and are all zero in cycles without a read.
- R2: When `dbl_lock` is 1, `core_powered` is 0, or `os_lock` is 1, a read returns `rsp_err`=1 and data zero, and it has no side effect on the shadows or the valid flag.
- R3: While `dbg_halted` or `prof_prohibit` is 1, a low-word read returns 0xFFFFFFFF with stale 0. Unless the side effect is suppressed (R8), it sets the high-word shadow, the NS shadow and the level shadow to zero.
- R4: A `br_retired` pulse while neither `dbg_halted` nor `prof_prohibit` is 1 captures `pc_in`, `ns_in` and `el_in`, and sets the valid flag. In any cycle with `dbg_halted` or `prof_prohibit` at 1, the valid flag is cleared and no capture takes place.
- R5: A low-word read with the valid flag set returns bits 31:0 of the captured address with stale 0. It loads the shadows with captured address bits 63:32, NS and level, and it clears the valid flag.
- R6: A low-word read with the valid flag clear returns bits 31:0 of the last captured address (zero after reset) with stale 1. It sets the shadows to zero.
- R7: When a low-word read and a `br_retired` pulse fall in the same cycle, the read returns the value captured before that cycle. The new capture stays valid for the next read.
- R8: A low-word read with `rd_mmio`=1 and `sw_lock`=1 returns its normal data, but leaves the shadows and the valid flag unchanged. With `rd_mmio`=0, `sw_lock` has no effect.
- R9: With `fmt_sel`=1, the high word is {NS shadow in bit 31, level shadow in bits 30:29, zero in bits 28:24, address bits 55:32 in bits 23:0}. NS is 1 for non-secure, and the level is 0 to 3.
- R10: With `fmt_sel`=0, the high word is address bits 63:32 when `hyp_present`=1, and zero otherwise.
- R11: An active-low synchronous reset clears the capture, the valid flag, the shadows and the response to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_in | input | 64 | Current instruction address |
| ns_in | input | 1 | Current state is non-secure |
| el_in | input | 2 | Current privilege level |
| br_retired | input | 1 | A branch retired this cycle |
| dbg_halted | input | 1 | Processor is halted in debug |
| prof_prohibit | input | 1 | Sample profiling is prohibited |
| dbl_lock | input | 1 | Double lock active |
| core_powered | input | 1 | Core power is on |
| os_lock | input | 1 | OS lock set |
| sw_lock | input | 1 | Software lock locked |
| hyp_present | input | 1 | Hypervisor level present |
| fmt_sel | input | 1 | High-word format select |
| rd_en | input | 1 | Read strobe |
| rd_mmio | input | 1 | Read comes from the memory-mapped path |
| rd_addr | input | 12 | Read byte offset |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Error response |
| rsp_data | output | 32 | Read data |
| rsp_stale | output | 1 | Low word returned a stale sample |

## Verification
The hardest case to reach is the cycle in which a consuming low-word read coincides with a new branch capture. The valid flag is then cleared and set again on the same edge, and the returned word must come from the older capture. The bench drives a read and a branch pulse in the same cycle with distinct addresses, then reads again, so that the stale and fresh paths are both observed. Suppressed side effects under the software lock are brought to the ports by following the locked read with a high-word read and then a plain low-word read.

// File: rtl/pcsamp_pkg.sv
package pcsamp_pkg;
  localparam int PC_W   = 64;
  localparam int WORD_W = 32;
  localparam int HI_W   = PC_W - WORD_W;
  localparam int ADDR_TAIL_W = 24;

  typedef struct packed {
    logic            ns;
    logic [1:0]      el;
    logic [HI_W-1:0] hi;
  } ctx_t;

  localparam logic [WORD_W-1:0] SENTINEL = '1;

  function automatic logic [WORD_W-1:0] fmt_high(input logic fmt, input logic hyp,
                                                 input ctx_t c);
    logic [WORD_W-1:0] w;
    if (fmt) w = {c.ns, c.el, {(WORD_W-3-ADDR_TAIL_W){1'b0}}, c.hi[ADDR_TAIL_W-1:0]};
    else if (hyp) w = c.hi;
    else w = '0;
    return w;
  endfunction
endpackage

// File: rtl/pcsamp_capture.sv
module pcsamp_capture
  import pcsamp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_ret,
  input  logic            blocked,
  input  logic            lo_take,
  input  logic [PC_W-1:0] pc_in,
  input  logic            ns_in,
  input  logic [1:0]      el_in,
  output logic [PC_W-1:0] cap_pc,
  output logic            cap_ns,
  output logic [1:0]      cap_el,
  output logic            cap_valid
);
  logic do_capture;
  assign do_capture = br_ret && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_pc    <= '0;
      cap_ns    <= 1'b0;
      cap_el    <= 2'b00;
      cap_valid <= 1'b0;
    end else if (blocked) begin
      cap_valid <= 1'b0;
    end else if (do_capture) begin
      cap_pc    <= pc_in;
      cap_ns    <= ns_in;
      cap_el    <= el_in;
      cap_valid <= 1'b1;
    end else if (lo_take) begin
      cap_valid <= 1'b0;
    end
  end

  a_r4_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    br_ret && !blocked |=> cap_valid && cap_pc == $past(pc_in) && cap_el == $past(el_in));
  a_r4_blocked_clears: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> !cap_valid);
  a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    lo_take && !br_ret && !blocked |=> !cap_valid);
  a_r7_new_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lo_take && br_ret && !blocked |=> cap_valid);
endmodule

// File: rtl/pcsamp_shadow.sv
module pcsamp_shadow
  import pcsamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sh_load,
  input  logic sh_clear,
  input  ctx_t src,
  output ctx_t shadow
);
  always_ff @(posedge clk) begin
    if (!rst_n)        shadow <= '0;
    else if (sh_load)  shadow <= src;
    else if (sh_clear) shadow <= '0;
  end

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sh_clear && !sh_load |=> shadow == '0);
  a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |=> shadow.hi == $past(src.hi) && shadow.ns == $past(src.ns));
endmodule

// File: rtl/pcsamp_rdport.sv
module pcsamp_rdport
  import pcsamp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 12'h0A0,
  parameter logic [ADDR_W-1:0] HI_OFS = 12'h0AC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_mmio,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              dbl_lock,
  input  logic              core_powered,
  input  logic              os_lock,
  input  logic              sw_lock,
  input  logic              blocked,
  input  logic              fmt_sel,
  input  logic              hyp_present,
  input  logic [WORD_W-1:0] cap_lo,
  input  logic              cap_valid,
  input  ctx_t              shadow,
  output logic              lo_take,
  output logic              sh_load,
  output logic              sh_clear,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_stale
);
  logic access_err, hit_lo, hit_hi, side_ok;
  logic [WORD_W-1:0] nxt_data;
  logic nxt_stale;

  assign access_err = dbl_lock || !core_powered || os_lock;
  assign hit_lo     = rd_en && !access_err && rd_addr == LO_OFS;
  assign hit_hi     = rd_en && !access_err && rd_addr == HI_OFS;
  assign side_ok    = !(rd_mmio && sw_lock);
  assign lo_take    = hit_lo && side_ok && !blocked;
  assign sh_load    = lo_take && cap_valid;
  assign sh_clear   = hit_lo && side_ok && (blocked || !cap_valid);

  always_comb begin
    nxt_data  = '0;
    nxt_stale = 1'b0;
    if (hit_lo) begin
      if (blocked) nxt_data = SENTINEL;
      else begin
        nxt_data  = cap_lo;
        nxt_stale = !cap_valid;
      end
    end else if (hit_hi) begin
      nxt_data = fmt_high(fmt_sel, hyp_present, shadow);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      rsp_stale <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      rsp_err   <= rd_en && access_err;
      rsp_data  <= nxt_data;
      rsp_stale <= nxt_stale;
    end
  end

  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_lo, hit_hi}));
  a_r2_error_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && access_err |=> rsp_err && rsp_data == '0 && rsp_valid);
  a_r2_no_side: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> !lo_take && !sh_load && !sh_clear);
  a_r3_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo && blocked |=> rsp_data == SENTINEL && !rsp_stale);
  a_r6_stale_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo && !blocked && !cap_valid |=> rsp_stale);
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mmio && sw_lock |-> !lo_take && !sh_load && !sh_clear);
endmodule

// File: rtl/pcsamp_unit.sv
module pcsamp_unit
  import pcsamp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 12'h0A0,
  parameter logic [ADDR_W-1:0] HI_OFS = 12'h0AC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       pc_in,
  input  logic              ns_in,
  input  logic [1:0]        el_in,
  input  logic              br_retired,
  input  logic              dbg_halted,
  input  logic              prof_prohibit,
  input  logic              dbl_lock,
  input  logic              core_powered,
  input  logic              os_lock,
  input  logic              sw_lock,
  input  logic              hyp_present,
  input  logic              fmt_sel,
  input  logic              rd_en,
  input  logic              rd_mmio,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_data,
  output logic              rsp_stale
);
  logic            blocked, lo_take, sh_load, sh_clear;
  logic [PC_W-1:0] cap_pc;
  logic            cap_ns, cap_valid;
  logic [1:0]      cap_el;
  ctx_t            cap_ctx, shadow;

  assign blocked = dbg_halted || prof_prohibit;
  assign cap_ctx = '{ns: cap_ns, el: cap_el, hi: cap_pc[PC_W-1:WORD_W]};

  pcsamp_capture u_cap (
    .clk(clk), .rst_n(rst_n), .br_ret(br_retired), .blocked(blocked),
    .lo_take(lo_take), .pc_in(pc_in), .ns_in(ns_in), .el_in(el_in),
    .cap_pc(cap_pc), .cap_ns(cap_ns), .cap_el(cap_el), .cap_valid(cap_valid)
  );

  pcsamp_shadow u_sh (
    .clk(clk), .rst_n(rst_n), .sh_load(sh_load), .sh_clear(sh_clear),
    .src(cap_ctx), .shadow(shadow)
  );

  pcsamp_rdport #(.ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_mmio(rd_mmio), .rd_addr(rd_addr),
    .dbl_lock(dbl_lock), .core_powered(core_powered), .os_lock(os_lock),
    .sw_lock(sw_lock), .blocked(blocked), .fmt_sel(fmt_sel), .hyp_present(hyp_present),
    .cap_lo(cap_pc[WORD_W-1:0]), .cap_valid(cap_valid), .shadow(shadow),
    .lo_take(lo_take), .sh_load(sh_load), .sh_clear(sh_clear),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data), .rsp_stale(rsp_stale)
  );

  a_r8_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_mmio && sw_lock |=> $stable(shadow));
  a_r5_fresh_no_stale: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |=> !rsp_stale && rsp_data == $past(cap_pc[WORD_W-1:0]));
endmodule

// File: tb/pcsamp_unit_test.sv
`timescale 1ns/1ps
module pcsamp_unit_test;
  logic clk = 0, rst_n = 0;
  logic [63:0] pc_in = '0;
  logic ns_in = 0;
  logic [1:0] el_in = 0;
  logic br_retired = 0, dbg_halted = 0, prof_prohibit = 0, dbl_lock = 0;
  logic core_powered = 1, os_lock = 0, sw_lock = 0, hyp_present = 1, fmt_sel = 0;
  logic rd_en = 0, rd_mmio = 0;
  logic [11:0] rd_addr = '0;
  logic rsp_valid, rsp_err, rsp_stale;
  logic [31:0] rsp_data;

  always #4 clk = ~clk;

  pcsamp_unit uut (.*);

  int checks = 0, failures = 0;
  string cur_req = "R11";

  // reference state
  logic [63:0] m_pc = '0;
  logic m_ns = 0, m_valid = 0;
  logic [1:0] m_el = 0;
  logic [31:0] m_hi = 0;
  logic m_shns = 0;
  logic [1:0] m_shel = 0;
  logic e_valid = 0, e_err = 0, e_stale = 0;
  logic [31:0] e_data = 0;

  task automatic model();
    bit lock_blk, bad, stopped;
    e_valid = 0; e_err = 0; e_stale = 0; e_data = 0;
    if (!rst_n) begin
      m_pc = 0; m_ns = 0; m_el = 0; m_valid = 0; m_hi = 0; m_shns = 0; m_shel = 0;
      return;
    end
    bad = dbl_lock | ~core_powered | os_lock;
    stopped = dbg_halted | prof_prohibit;
    lock_blk = rd_mmio & sw_lock;
    if (rd_en) begin
      e_valid = 1;
      if (bad) e_err = 1;
      else if (rd_addr == 12'h0A0) begin
        if (stopped) begin
          e_data = 32'hFFFF_FFFF;
          if (!lock_blk) begin m_hi = 0; m_shns = 0; m_shel = 0; end
        end else begin
          e_data = m_pc[31:0];
          e_stale = !m_valid;
          if (!lock_blk) begin
            if (m_valid) begin m_hi = m_pc >> 32; m_shns = m_ns; m_shel = m_el; end
            else begin m_hi = 0; m_shns = 0; m_shel = 0; end
            m_valid = 0;
          end
        end
      end else if (rd_addr == 12'h0AC) begin
        if (fmt_sel) e_data = (32'(m_shns) << 31) | (32'(m_shel) << 29) | (m_hi & 32'h00FF_FFFF);
        else e_data = hyp_present ? m_hi : 32'h0;
      end
    end
    if (stopped) m_valid = 0;
    else if (br_retired) begin m_pc = pc_in; m_ns = ns_in; m_el = el_in; m_valid = 1; end
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    #2;
    checks++;
    if ({rsp_valid, rsp_err, rsp_stale, rsp_data} !== {e_valid, e_err, e_stale, e_data}) begin
      failures++;
      $display("FAIL %s: got v=%0b e=%0b s=%0b d=%h exp v=%0b e=%0b s=%0b d=%h", cur_req,
               rsp_valid, rsp_err, rsp_stale, rsp_data, e_valid, e_err, e_stale, e_data);
    end
    rd_en = 0; br_retired = 0;
  endtask

  task automatic br(input logic [63:0] pc, input logic ns, input logic [1:0] el);
    pc_in = pc; ns_in = ns; el_in = el; br_retired = 1; tick();
  endtask

  task automatic rd(input logic [11:0] a, input logic mmio);
    rd_addr = a; rd_mmio = mmio; rd_en = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got hang exp finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R11";
    repeat (3) tick();
    rst_n = 1;
    tick();
    rd(12'h0AC, 0);                           // R11 shadows zero
    cur_req = "R6"; rd(12'h0A0, 0);           // R6 stale zero after reset
    cur_req = "R4"; br(64'h1234_5678_9ABC_DEF0, 1, 2'b10);
    cur_req = "R5"; rd(12'h0A0, 0);
    cur_req = "R10"; rd(12'h0AC, 0);
    hyp_present = 0; rd(12'h0AC, 0); hyp_present = 1;
    cur_req = "R9"; fmt_sel = 1; rd(12'h0AC, 0); fmt_sel = 0;
    cur_req = "R6"; rd(12'h0A0, 0); rd(12'h0AC, 0);
    cur_req = "R7"; br(64'hAAAA_0001_BBBB_0001, 0, 2'b01);
    pc_in = 64'hCCCC_0002_DDDD_0002; br_retired = 1; rd_addr = 12'h0A0; rd_en = 1; tick();
    rd(12'h0A0, 0); rd(12'h0AC, 0);
    cur_req = "R3"; br(64'h0000_0003_0000_0003, 1, 2'b11);
    dbg_halted = 1; rd(12'h0A0, 0); br(64'h9, 0, 0); dbg_halted = 0;
    rd(12'h0A0, 0); rd(12'h0AC, 0);
    prof_prohibit = 1; br(64'h0000_0004_0000_0004, 1, 1); rd(12'h0A0, 1); prof_prohibit = 0;
    rd(12'h0A0, 0);
    cur_req = "R2"; br(64'h0000_0005_0000_0005, 1, 1);
    os_lock = 1; rd(12'h0A0, 0); os_lock = 0;
    dbl_lock = 1; rd(12'h0AC, 0); dbl_lock = 0;
    core_powered = 0; rd(12'h0A0, 1); core_powered = 1;
    rd(12'h0A0, 0);
    cur_req = "R8"; br(64'h0000_0006_0000_0006, 0, 2); rd(12'h0A0, 0);
    br(64'h0000_0007_0000_0007, 1, 3);
    sw_lock = 1; rd(12'h0A0, 1); rd(12'h0AC, 1);
    rd(12'h0A0, 0); rd(12'h0AC, 0); sw_lock = 0;
    cur_req = "R1"; rd(12'h004, 0); rd(12'h0A4, 1); tick();
    cur_req = "R4";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 16;
      pc_in = {$urandom, $urandom}; ns_in = r[0]; el_in = r[2:1];
      br_retired = ($urandom % 3) == 0;
      dbg_halted = ($urandom % 12) == 0;
      prof_prohibit = ($urandom % 15) == 0;
      sw_lock = ($urandom % 5) == 0;
      os_lock = ($urandom % 20) == 0;
      fmt_sel = r[3]; hyp_present = ($urandom % 4) != 0;
      rd_mmio = $urandom % 2;
      rd_en = ($urandom % 2) == 0;
      case ($urandom % 3) 0: rd_addr = 12'h0A0; 1: rd_addr = 12'h0AC; default: rd_addr = 12'h010; endcase
      tick();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule